// File: doc/BRIEF.md
# Prefix-Tree Magnitude Comparator

This block compares two unsigned operands of a configurable width and raises exactly one of three flags: the second operand is larger, the first operand is larger, or the two are equal. It does not use a subtractor or a ripple chain. Each bit position is first reduced to a pair of signals. One says that the second operand wins at that bit. The other says the two bits match. A binary tree then merges neighbouring groups level by level, in the same way as the carry-merge network of a parallel-prefix adder. Only the root of the tree is used, so the logic depth grows with log2 of the width.

A width that is not a power of two is padded above the top bit with positions that encode as matching. Those positions can never change the answer. A parameter selects between purely combinational flags and flags captured on the rising clock edge. The captured flags are cleared while the active-low reset is held. The whole comparison fits in one cycle, with no internal pipelining.

Top module: `prefix_mag_cmp`

## Requirements
- R1: The equal flag `eq` is 1 exactly when `op_a` equals `op_b`.
- R2: The flag `b_gt` is 1 exactly when `op_b` is larger than `op_a` as unsigned numbers.
- R3: The flag `a_gt` is 1 exactly when `op_a` is larger than `op_b` as unsigned numbers.
- R4: Outside reset, exactly one of `b_gt`, `a_gt` and `eq` is 1 for any operand pair.
- R5: The most significant bit at which the operands differ decides the result, whatever the lower bits hold. This covers a difference in the top bit alone, and a difference in bit 0 alone.
- R6: When `N` is not a power of two, the flags still follow R1 to R3 over all input pairs.
- R7: With `REG_OUT` = 1, the flags show the comparison of the operands present at the previous rising edge of `clk`. They hold their value between edges even when the operands change.
- R8: With `REG_OUT` = 1, all three flags read 0 while `rst_n` is 0.
- R9: With `REG_OUT` = 0, the flags follow the operands without waiting for a clock edge.
- R10: With `N` = 1, the pairs (a,b) = (0,0) and (1,1) give `eq`, (0,1) gives `b_gt`, and (1,0) gives `a_gt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; used only when `REG_OUT` = 1 |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_a | input | N | First unsigned operand |
| op_b | input | N | Second unsigned operand |
| b_gt | output | 1 | `op_b` is larger than `op_a` |
| a_gt | output | 1 | `op_a` is larger than `op_b` |
| eq | output | 1 | The operands are equal |

## Verification
In registered mode, two events can fall on the same cycle. One is the clearing of the flags by reset. The other is the capture of a fresh comparison. The bench provokes this by holding unequal operands on the inputs through reset, and it requires all-zero flags until the first edge after release. A second overlap comes when operands change between edges while the captured result is still on display. The bench drives a new pair half a cycle before the edge and requires the old result just before the edge and the new one just after it.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef struct packed {
    logic b_gt;
    logic a_gt;
    logic eq;
  } pmc_flags_t;

  localparam pmc_flags_t PMC_CLEAR = '0;

  // number of merge levels above the bit encoders for a given width
  function automatic int pmc_levels(input int width);
    return (width > 1) ? $clog2(width) : 0;
  endfunction

endpackage

// File: rtl/pmc_preenc.sv
module pmc_preenc #(
  parameter int N = 64,
  parameter int W = 64
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] eq_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < N) begin : g_real
      assign gen_o[i] = ~a_i[i] & b_i[i];
      assign eq_o[i]  = ~(a_i[i] ^ b_i[i]);
    end else begin : g_pad
      // padded position: never wins, always matches
      assign gen_o[i] = 1'b0;
      assign eq_o[i]  = 1'b1;
    end
  end

endmodule

// File: rtl/pmc_tree.sv
module pmc_tree #(
  parameter int W    = 64,
  parameter int LVLS = 6
) (
  input  logic [W-1:0] gen_i,
  input  logic [W-1:0] eq_i,
  output logic         root_gen,
  output logic         root_eq
);

  logic [W-1:0] g_l [LVLS+1];
  logic [W-1:0] e_l [LVLS+1];

  assign g_l[0] = gen_i;
  assign e_l[0] = eq_i;

  for (genvar l = 0; l < LVLS; l++) begin : g_lvl
    localparam int CNT = W >> (l + 1);
    for (genvar j = 0; j < CNT; j++) begin : g_node
      // upper group decides unless it matches, then lower group decides
      assign g_l[l+1][j] = g_l[l][2*j+1] | (e_l[l][2*j+1] & g_l[l][2*j]);
      assign e_l[l+1][j] = e_l[l][2*j+1] & e_l[l][2*j];
    end
    if (CNT < W) begin : g_fill
      assign g_l[l+1][W-1:CNT] = '0;
      assign e_l[l+1][W-1:CNT] = '0;
    end
  end

  assign root_gen = g_l[LVLS][0];
  assign root_eq  = e_l[LVLS][0];

endmodule

// File: rtl/pmc_outreg.sv
module pmc_outreg
  import pmc_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  pmc_flags_t flags_i,
  output pmc_flags_t flags_o
);

  if (REG_OUT != 0) begin : g_reg
    pmc_flags_t flags_d;
    pmc_flags_t flags_q;
    logic       flags_en;

    always_comb begin
      flags_en = 1'b1;
      flags_d  = flags_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q <= PMC_CLEAR;
      end else if (flags_en) begin
        flags_q <= flags_d;
      end
    end

    assign flags_o = flags_q;
  end else begin : g_comb
    assign flags_o = flags_i;
  end

endmodule

// File: rtl/prefix_mag_cmp.sv
module prefix_mag_cmp
  import pmc_pkg::*;
#(
  parameter int N       = 64,
  parameter int REG_OUT = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  output logic         b_gt,
  output logic         a_gt,
  output logic         eq
);

  localparam int LVLS = pmc_levels(N);
  localparam int W    = 1 << LVLS;

  logic [W-1:0] bit_gen;
  logic [W-1:0] bit_eq;
  logic         root_gen;
  logic         root_eq;
  pmc_flags_t   flags_raw;
  pmc_flags_t   flags_out;

  pmc_preenc #(.N(N), .W(W)) u_preenc (
    .a_i   (op_a),
    .b_i   (op_b),
    .gen_o (bit_gen),
    .eq_o  (bit_eq)
  );

  pmc_tree #(.W(W), .LVLS(LVLS)) u_tree (
    .gen_i    (bit_gen),
    .eq_i     (bit_eq),
    .root_gen (root_gen),
    .root_eq  (root_eq)
  );

  always_comb begin
    flags_raw.b_gt = root_gen;
    flags_raw.eq   = root_eq;
    flags_raw.a_gt = ~root_gen & ~root_eq;
  end

  pmc_outreg #(.REG_OUT(REG_OUT)) u_outreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags_raw),
    .flags_o (flags_out)
  );

  assign b_gt = flags_out.b_gt;
  assign a_gt = flags_out.a_gt;
  assign eq   = flags_out.eq;

endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int N       = 64,
  parameter int REG_OUT = 1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic         b_gt,
  input logic         a_gt,
  input logic         eq
);

  if (REG_OUT != 0) begin : g_reg_chk
    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $countones({b_gt, a_gt, eq}) == 1); // R4
    AST_EQ_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> eq == ($past(op_a) == $past(op_b))); // R1
    AST_BGT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> b_gt == ($past(op_a) < $past(op_b))); // R2
    AST_AGT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> a_gt == ($past(op_a) > $past(op_b))); // R3

    always @(negedge clk) begin
      if (!rst_n) begin
        AST_RESET_CLEAR: assert ({b_gt, a_gt, eq} == 3'b000); // R8
      end
    end
  end else begin : g_comb_chk
    AST_ONE_FLAG_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({b_gt, a_gt, eq}) == 1); // R4
    AST_EQ_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      eq == (op_a == op_b)); // R1
    AST_BGT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      b_gt == (op_a < op_b)); // R2
    AST_AGT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      a_gt == (op_a > op_b)); // R3
  end

endmodule

bind prefix_mag_cmp pmc_checker #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op_a  (op_a),
  .op_b  (op_b),
  .b_gt  (b_gt),
  .a_gt  (a_gt),
  .eq    (eq)
);

// File: tb/prefix_mag_cmp_tb.sv
module prefix_mag_cmp_tb;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;

  logic [63:0] a64 = '0, b64 = '0;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [4:0]  a5 = '0, b5 = '0;
  logic        a1 = 1'b0, b1 = 1'b0;

  logic f64_b, f64_a, f64_e;
  logic f4_b, f4_a, f4_e;
  logic f5_b, f5_a, f5_e;
  logic f1_b, f1_a, f1_e;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  prefix_mag_cmp #(.N(64), .REG_OUT(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(a64), .op_b(b64),
    .b_gt(f64_b), .a_gt(f64_a), .eq(f64_e));

  prefix_mag_cmp #(.N(4), .REG_OUT(0)) u_dut4 (
    .clk(clk), .rst_n(rst_n), .op_a(a4), .op_b(b4),
    .b_gt(f4_b), .a_gt(f4_a), .eq(f4_e));

  prefix_mag_cmp #(.N(5), .REG_OUT(1)) u_dut5 (
    .clk(clk), .rst_n(rst_n), .op_a(a5), .op_b(b5),
    .b_gt(f5_b), .a_gt(f5_a), .eq(f5_e));

  prefix_mag_cmp #(.N(1), .REG_OUT(0)) u_dut1 (
    .clk(clk), .rst_n(rst_n), .op_a(a1), .op_b(b1),
    .b_gt(f1_b), .a_gt(f1_a), .eq(f1_e));

  function automatic logic [2:0] ref3(input logic [63:0] a, input logic [63:0] b);
    return {a < b, a > b, a == b};
  endfunction

  function automatic string tag_of(input logic [2:0] e);
    return e[0] ? "R1" : (e[2] ? "R2" : "R3");
  endfunction

  task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %b expected %b", req, got, exp);
    end
  endtask

  task automatic chk_flags(input string extra, input logic [2:0] got, input logic [2:0] exp);
    chk({tag_of(exp), " ", extra}, got, exp);
    chk({"R4 ", extra}, {2'b00, $countones(got) == 1}, 3'b001);
  endtask

  task automatic t_reset();
    a64 = 64'd7; b64 = 64'd9; a5 = 5'd3; b5 = 5'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 n64 in reset", {f64_b, f64_a, f64_e}, 3'b000);
    chk("R8 n5 in reset", {f5_b, f5_a, f5_e}, 3'b000);
    rst_n = 1'b1;
    #1;
    chk("R8 n64 before first edge", {f64_b, f64_a, f64_e}, 3'b000);
    @(posedge clk); #1;
    chk("R7 n64 first edge", {f64_b, f64_a, f64_e}, 3'b100);
    chk("R7 n5 first edge", {f5_b, f5_a, f5_e}, 3'b010);
  endtask

  task automatic t_exh4();
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        a4 = 4'(a); b4 = 4'(b);
        #1;
        chk_flags("R9 n4", {f4_b, f4_a, f4_e}, ref3(64'(a), 64'(b)));
      end
    end
  endtask

  task automatic t_exh5();
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        @(negedge clk);
        a5 = 5'(a); b5 = 5'(b);
        @(posedge clk); #1;
        chk_flags("R6 n5", {f5_b, f5_a, f5_e}, ref3(64'(a), 64'(b)));
      end
    end
  endtask

  task automatic t_one_bit();
    for (int v = 0; v < 4; v++) begin
      a1 = v[1]; b1 = v[0];
      #1;
      chk("R10 n1", {f1_b, f1_a, f1_e}, ref3(64'(v[1]), 64'(v[0])));
    end
  endtask

  task automatic apply64(input logic [63:0] a, input logic [63:0] b, input string extra);
    @(negedge clk);
    a64 = a; b64 = b;
    @(posedge clk); #1;
    chk_flags(extra, {f64_b, f64_a, f64_e}, ref3(a, b));
  endtask

  task automatic t_priority();
    apply64(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R5 msb a");
    apply64(64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, "R5 msb b");
    apply64(64'hA5A5_0F0F_3C3C_FFFE, 64'hA5A5_0F0F_3C3C_FFFF, "R5 lsb b");
    apply64(64'h0000_0000_0000_0001, 64'h0000_0000_0000_0000, "R5 lsb a");
    apply64(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, "R1 all ones");
    apply64(64'h0, 64'h0, "R1 all zero");
  endtask

  task automatic t_latency();
    apply64(64'd1, 64'd2, "R7 setup");
    @(negedge clk);
    a64 = 64'd5; b64 = 64'd3;
    #1;
    chk("R7 hold between edges", {f64_b, f64_a, f64_e}, 3'b100);
    @(posedge clk); #1;
    chk("R7 after edge", {f64_b, f64_a, f64_e}, 3'b010);
  endtask

  task automatic t_random();
    for (int k = 0; k < 300; k++) begin
      logic [63:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = (k % 5 == 0) ? ra : {$urandom(), $urandom()};
      if (k % 7 == 1) rb = ra ^ (64'd1 << (k % 64));
      apply64(ra, rb, "n64 random");
    end
  endtask

  initial begin
    t_reset();
    t_exh4();
    t_one_bit();
    t_priority();
    t_latency();
    t_random();
    t_exh5();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule